// File: doc/BRIEF.md
# Encoded Ratio Controller Clock Divider

This block derives a controller clock from a fast source clock. Software writes a small configuration word: a 3-bit ratio code, a clock-enable bit, a bypass bit and a divider-hold bit. The ratio code selects one of eight division ratios. Most of them are powers of two, but two of them (6 and 24) are not. When bypass is set, the output carries a clock from an external pin in place of the divided clock.

A new ratio reaches the counter only while the divider-hold bit is set. The output stays low during hold and starts a fresh period once hold is cleared, so a ratio change never produces a runt pulse. Clearing the enable stops the output only at the end of a high phase, so pulses are never cut short. The bypass path uses a cross-coupled two-stage handover: each source is released only while its clock is low. The written ratio code and enable bit read back unchanged, which lets software confirm its programming.

Top module: `ctlclk_div`

## Requirements
- R1: Ratio codes 0 to 7 divide the source clock by 1, 2, 4, 6, 8, 16, 24 and 32 respectively. In steady state the output shows exactly 96/N rising edges in any window of 96 source cycles.
- R2: A ratio code written while the divider-hold bit is 0 does not change the running ratio. It takes effect only after a later write sets hold to 1 and a following write clears it.
- R3: While the divider-hold bit is 1, the output has no rising edge and stays low. After hold is cleared, the divider begins counting at the next source edge.
- R4: For every even ratio the output is high for exactly half of each period. Ratio code 0 passes the source clock through with its own duty.
- R5: While the enable bit is 0, no rising edge appears on the output. Disabling never shortens a high phase that is already under way.
- R6: After a configuration write, rd_sel equals the written ratio code and rd_clk_en equals the written enable bit, whatever the divider state.
- R7: With the bypass bit at 1, the output follows pin_clk. With it at 0, the output follows the divided source clock.
- R8: A bypass change produces no output high or low phase shorter than the shorter of the two sources' half-periods.
- R9: After rst_n, the ratio code is 0, enable is 0, bypass is 0, divider hold is 1, and the output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| src_clk | input | 1 | Fast source clock to be divided |
| pin_clk | input | 1 | External clock used in bypass |
| wr_en | input | 1 | Configuration write strobe, sampled on src_clk |
| wr_sel | input | 3 | Ratio code to write |
| wr_clk_en | input | 1 | Output clock enable to write |
| wr_byp | input | 1 | Bypass select to write (1 = pin_clk) |
| wr_div_rst | input | 1 | Divider-hold bit to write |
| rd_sel | output | 3 | Readback of the stored ratio code |
| rd_clk_en | output | 1 | Readback of the stored enable bit |
| ctl_clk | output | 1 | Controller clock output |

## Verification
The bench uses the fixed 3-bit code table and a 16 ns pin clock against a 5 ns source clock. The least common multiple of all eight ratios is 96, so a single 96-cycle window gives an exact edge count and an exact high-time count for every code, with no tolerance. High time is sampled every half nanosecond on a grid offset from all clock edges. A width monitor records the shortest output phase while bypass switches in both directions, which covers the pass-through ratio, a power-of-two ratio and a disable during a long ratio.

// File: rtl/ctlclk_div.sv
module ctlclk_div (
  input  logic       rst_n,
  input  logic       src_clk,
  input  logic       pin_clk,
  input  logic       wr_en,
  input  logic [2:0] wr_sel,
  input  logic       wr_clk_en,
  input  logic       wr_byp,
  input  logic       wr_div_rst,
  output logic [2:0] rd_sel,
  output logic       rd_clk_en,
  output logic       ctl_clk
);
  localparam int CW = 4;

  logic [2:0]    sel_r, ratio;
  logic          en_r, byp_r, hold_r;
  logic [CW-1:0] cnt, lim;
  logic          q, gate1, div_clk;
  logic          a1, a2, b1, b2;
  logic          div_high;

  always_ff @(posedge src_clk or negedge rst_n)
    if (!rst_n) begin
      sel_r  <= '0;
      en_r   <= 1'b0;
      byp_r  <= 1'b0;
      hold_r <= 1'b1;
    end else if (wr_en) begin
      sel_r  <= wr_sel;
      en_r   <= wr_clk_en;
      byp_r  <= wr_byp;
      hold_r <= wr_div_rst;
    end

  assign rd_sel    = sel_r;
  assign rd_clk_en = en_r;

  always_comb
    case (ratio)
      3'd1:    lim = CW'(0);
      3'd2:    lim = CW'(1);
      3'd3:    lim = CW'(2);
      3'd4:    lim = CW'(3);
      3'd5:    lim = CW'(7);
      3'd6:    lim = CW'(11);
      3'd7:    lim = CW'(15);
      default: lim = CW'(0);
    endcase

  always_ff @(posedge src_clk or negedge rst_n)
    if (!rst_n) begin
      ratio <= '0;
      cnt   <= '0;
      q     <= 1'b0;
    end else if (hold_r) begin
      ratio <= sel_r;
      cnt   <= '0;
      q     <= 1'b0;
    end else if (ratio == 3'd0) begin
      cnt <= '0;
      q   <= 1'b0;
    end else if (cnt == lim) begin
      cnt <= '0;
      q   <= q ? 1'b0 : en_r;
    end else begin
      cnt <= cnt + CW'(1);
    end

  always_ff @(negedge src_clk or negedge rst_n)
    if (!rst_n) gate1 <= 1'b0;
    else        gate1 <= en_r & ~hold_r & (ratio == 3'd0);

  assign div_clk  = (ratio == 3'd0) ? (src_clk & gate1) : q;
  assign div_high = (ratio != 3'd0) & q;

  always_ff @(negedge src_clk or negedge rst_n)
    if (!rst_n) begin
      a1 <= 1'b1;
      a2 <= 1'b1;
    end else begin
      a1 <= ~byp_r & ~b2;
      if (!div_high) a2 <= a1;
    end

  always_ff @(negedge pin_clk or negedge rst_n)
    if (!rst_n) begin
      b1 <= 1'b0;
      b2 <= 1'b0;
    end else begin
      b1 <= byp_r & ~a2;
      b2 <= b1;
    end

  assign ctl_clk = (div_clk & a2) | (pin_clk & b2);
endmodule

module ctlclk_div_chk (
  input logic       src_clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [2:0] wr_sel,
  input logic       wr_clk_en,
  input logic [2:0] rd_sel,
  input logic       rd_clk_en,
  input logic       hold_r,
  input logic       en_r,
  input logic       q,
  input logic [2:0] ratio,
  input logic       a2,
  input logic       b2
);
  AST_RB_MATCH: assert property (@(posedge src_clk) disable iff (!rst_n)
    wr_en |=> (rd_sel == $past(wr_sel)) && (rd_clk_en == $past(wr_clk_en))); // R6
  AST_HOLD_LOW: assert property (@(posedge src_clk) disable iff (!rst_n)
    hold_r |=> !q); // R3
  AST_RATIO_FROZEN: assert property (@(posedge src_clk) disable iff (!rst_n)
    !hold_r |=> $stable(ratio)); // R2
  AST_NO_RISE_OFF: assert property (@(posedge src_clk) disable iff (!rst_n)
    (!en_r && !q) |=> !q); // R5
  AST_MUX_EXCL: assert property (@(posedge src_clk) disable iff (!rst_n)
    !(a2 && b2)); // R8
endmodule

bind ctlclk_div ctlclk_div_chk u_chk (
  .src_clk(src_clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
  .wr_clk_en(wr_clk_en), .rd_sel(rd_sel), .rd_clk_en(rd_clk_en),
  .hold_r(hold_r), .en_r(en_r), .q(q), .ratio(ratio), .a2(a2), .b2(b2)
);

// File: tb/tb_ctlclk_div.sv
`timescale 1ns/10ps
module tb_ctlclk_div;
  logic rst_n, clk, pin_clk, wr_en, wr_clk_en, wr_byp, wr_div_rst;
  logic [2:0] wr_sel, rd_sel;
  logic rd_clk_en, ctl_clk;
  int checks = 0, fails = 0;
  int edges = 0;
  bit counting = 0, mon = 0, have = 0;
  realtime last_t, minw;

  ctlclk_div dut (.rst_n(rst_n), .src_clk(clk), .pin_clk(pin_clk), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_clk_en(wr_clk_en), .wr_byp(wr_byp), .wr_div_rst(wr_div_rst),
    .rd_sel(rd_sel), .rd_clk_en(rd_clk_en), .ctl_clk(ctl_clk));

  initial begin clk = 0; forever #2.5 clk = ~clk; end
  initial begin pin_clk = 0; forever #8 pin_clk = ~pin_clk; end

  always @(posedge ctl_clk) if (counting) edges++;
  always @(ctl_clk) begin
    if (mon && have && ($realtime - last_t) < minw) minw = $realtime - last_t;
    last_t = $realtime;
    have = 1;
  end

  function automatic int ratio_of(input int c);
    case (c)
      0: return 1; 1: return 2; 2: return 4; 3: return 6;
      4: return 8; 5: return 16; 6: return 24; default: return 32;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int s, input bit en, input bit byp, input bit hold);
    @(negedge clk);
    wr_sel = 3'(s); wr_clk_en = en; wr_byp = byp; wr_div_rst = hold; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic measure(output int e, output int hi);
    @(negedge clk);
    #0.25;
    edges = 0; hi = 0; counting = 1;
    repeat (960) begin hi += int'(ctl_clk); #0.5; end
    counting = 0;
    e = edges;
  endtask

  task automatic settle(); repeat (80) @(posedge clk); endtask

  task automatic mon_start(); have = 0; minw = 1.0e9; mon = 1; endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int e, hi;
    rst_n = 0; wr_en = 0; wr_sel = 0; wr_clk_en = 0; wr_byp = 0; wr_div_rst = 0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    settle();
    // R9 reset state
    chk("R9 rd_sel", int'(rd_sel), 0);
    chk("R9 rd_clk_en", int'(rd_clk_en), 0);
    measure(e, hi);
    chk("R9 edges", e, 0);

    for (int c = 0; c < 8; c++) begin
      wr(c, 1, 0, 1);
      chk("R6 sel readback", int'(rd_sel), c);
      chk("R6 en readback", int'(rd_clk_en), 1);
      settle();
      measure(e, hi);
      chk("R3 held edges", e, 0);
      chk("R3 held high", hi, 0);
      wr(c, 1, 0, 0);
      settle();
      measure(e, hi);
      chk("R1 edges", e, 96 / ratio_of(c));
      chk("R4 high samples", hi, 480);
    end

    // R2: ratio write without hold is ignored until a hold cycle
    wr(3, 1, 0, 1); wr(3, 1, 0, 0); settle();
    wr(7, 1, 0, 0);
    chk("R6 sel readback running", int'(rd_sel), 7);
    settle();
    measure(e, hi);
    chk("R2 old ratio kept", e, 16);
    wr(7, 1, 0, 1); wr(7, 1, 0, 0); settle();
    measure(e, hi);
    chk("R2 new ratio after hold", e, 3);

    // R5: disable at div16, no truncated high phase
    wr(5, 1, 0, 1); wr(5, 1, 0, 0); settle();
    mon_start();
    wr(5, 0, 0, 0);
    chk("R6 en readback off", int'(rd_clk_en), 0);
    settle();
    measure(e, hi);
    chk("R5 edges off", e, 0);
    chk("R5 high off", hi, 0);
    wr(5, 1, 0, 0); settle(); settle();
    mon = 0;
    chk("R5 min width x100", int'(minw * 100.0 + 0.5) >= 4000 ? 1 : 0, 1);
    measure(e, hi);
    chk("R5 edges back on", e, 6);

    // R7/R8: bypass switch at div4 (half 10ns) and div1 (half 2.5ns), pin half 8ns
    for (int k = 0; k < 2; k++) begin
      int c = (k == 0) ? 2 : 0;
      int lo = (k == 0) ? 800 : 250;
      wr(c, 1, 0, 1); wr(c, 1, 0, 0); settle();
      mon_start();
      wr(c, 1, 1, 0); settle();
      measure(e, hi);
      chk("R7 pin edges", e, 30);
      chk("R7 pin high", hi, 480);
      wr(c, 1, 0, 0); settle();
      measure(e, hi);
      chk("R7 back to divided", e, 96 / ratio_of(c));
      mon = 0;
      chk("R8 min width x100", int'(minw * 100.0 + 0.5) >= lo ? 1 : 0, 1);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule